// File: doc/BRIEF.md
# Region Protection Address Translator

This block maps virtual addresses to physical addresses for a processor that has no paging unit. The address space is cut into eight equal regions of 512 MB. The three most significant address bits pick one region entry. Each entry holds the upper physical address bits and a four-bit attribute code. The translated address keeps the low 29 offset bits unchanged and takes its top bits from the entry.

The attribute code is decoded into read, write and execute rights, and the rights are checked against the kind of access. A denied access reports a fault cause code that depends on the access kind. Each result is registered and appears one clock after the request.

Region entries are loaded through a simple write port. On reset every region maps onto itself.

Top module: `region_xlat`

## Requirements
- R1: The region index is vaddr[31:29]. A granted access returns paddr = {entry base (3 bits), vaddr[28:0]}. A faulting access returns paddr 0.
- R2: Read and write rights are both granted when the attribute is one of 0, 1, 2, 4, 5 or 14. For every other value both are denied. rights bit0 is read and bit1 is write.
- R3: The execute right (rights bit2) is granted exactly when the attribute is 1, 2, 3, 4 or 5.
- R4: Access kinds are 0 = load (needs read), 1 = store (needs write) and 2 = fetch (needs execute). A denied access sets fault and gives cause 1 for a load, 2 for a store or 3 for a fetch. A granted access gives fault 0 and cause 0.
- R5: Access kind 3 is always denied, with fault 1 and cause 2. The rights of the region are still reported.
- R6: After reset, region i has base i and attribute 2.
- R7: When the write enable is high at a clock edge, the entry at wr_idx takes wr_base and wr_attr. A request presented in that same cycle is translated with the entry's previous contents, and later requests see the new contents.
- R8: A request accepted at one clock edge gives rsp_valid_o high after that edge, together with its result. Without a request, all response outputs are 0 after the edge. All response outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 invalid |
| wr_en_i | input | 1 | Region entry write enable |
| wr_idx_i | input | 3 | Region entry to write |
| wr_base_i | input | 3 | New physical base (address bits 31:29) |
| wr_attr_i | input | 4 | New attribute code |
| rsp_valid_o | output | 1 | Registered result valid |
| rsp_paddr_o | output | 32 | Physical address, 0 on fault |
| rsp_fault_o | output | 1 | Access denied |
| rsp_cause_o | output | 2 | Fault cause: 0 none, 1 load, 2 store, 3 fetch |
| rsp_rights_o | output | 3 | Rights of the selected region: bit0 read, bit1 write, bit2 execute |

## Verification
The properties assume that every request and write input holds a known value at each rising edge once reset has been released. They also assume that any 2-bit kind code may occur, including the invalid code 3. The stimulus changes all inputs only on the falling clock edge and holds them at zero throughout reset. The stimulus covers all sixteen attribute codes against all four kind codes. It also issues a write to a region together with a request to the same region, so the one-cycle visibility rule is exercised.

// File: rtl/region_xlat_pkg.sv
package region_xlat_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_BAD   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_LOAD  = 2'd1,
        CAUSE_STORE = 2'd2,
        CAUSE_FETCH = 2'd3
    } cause_e;

    // Packed so that rd lands on bit 0.
    typedef struct packed {
        logic ex;
        logic wr;
        logic rd;
    } rights_t;

endpackage

// File: rtl/region_xlat_table.sv
module region_xlat_table #(
    parameter int                IDX_W    = 3,
    parameter int                ATTR_W   = 4,
    parameter logic [ATTR_W-1:0] RST_ATTR = 4'd2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [IDX_W-1:0]  wr_base_i,
    input  logic [ATTR_W-1:0] wr_attr_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [IDX_W-1:0]  rd_base_o,
    output logic [ATTR_W-1:0] rd_attr_o
);
    localparam int NREG = 1 << IDX_W;

    logic [IDX_W-1:0]  base_d [NREG];
    logic [IDX_W-1:0]  base_q [NREG];
    logic [ATTR_W-1:0] attr_d [NREG];
    logic [ATTR_W-1:0] attr_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_comb begin
            base_d[g] = base_q[g];
            attr_d[g] = attr_q[g];
            if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                base_d[g] = wr_base_i;
                attr_d[g] = wr_attr_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                base_q[g] <= IDX_W'(g);
                attr_q[g] <= RST_ATTR;
            end else begin
                base_q[g] <= base_d[g];
                attr_q[g] <= attr_d[g];
            end
        end
    end

    assign rd_base_o = base_q[rd_idx_i];
    assign rd_attr_o = attr_q[rd_idx_i];

endmodule

// File: rtl/region_xlat_perm.sv
module region_xlat_perm
    import region_xlat_pkg::*;
#(
    parameter int ATTR_W = 4
) (
    input  logic [ATTR_W-1:0] attr_i,
    output rights_t           rights_o
);
    logic low_code;
    logic rw_ok;
    logic ex_ok;

    always_comb begin
        low_code = attr_i < ATTR_W'(6);
        rw_ok    = (low_code && (attr_i != ATTR_W'(3))) || (attr_i == ATTR_W'(14));
        ex_ok    = low_code && (attr_i != '0);
        rights_o = '{ex: ex_ok, wr: rw_ok, rd: rw_ok};
    end

endmodule

// File: rtl/region_xlat_judge.sv
module region_xlat_judge
    import region_xlat_pkg::*;
(
    input  acc_kind_e kind_i,
    input  rights_t   rights_i,
    output logic      grant_o,
    output cause_e    cause_o
);
    always_comb begin
        unique case (kind_i)
            KIND_LOAD:  grant_o = rights_i.rd;
            KIND_STORE: grant_o = rights_i.wr;
            KIND_FETCH: grant_o = rights_i.ex;
            default:    grant_o = 1'b0;
        endcase

        if (grant_o) begin
            cause_o = CAUSE_NONE;
        end else if (kind_i == KIND_LOAD) begin
            cause_o = CAUSE_LOAD;
        end else if (kind_i == KIND_FETCH) begin
            cause_o = CAUSE_FETCH;
        end else begin
            cause_o = CAUSE_STORE;
        end
    end

endmodule

// File: rtl/region_xlat.sv
module region_xlat
    import region_xlat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3,
    parameter int ATTR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_vaddr_i,
    input  logic [1:0]        req_kind_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [IDX_W-1:0]  wr_base_i,
    input  logic [ATTR_W-1:0] wr_attr_i,
    output logic              rsp_valid_o,
    output logic [ADDR_W-1:0] rsp_paddr_o,
    output logic              rsp_fault_o,
    output logic [1:0]        rsp_cause_o,
    output logic [2:0]        rsp_rights_o
);
    localparam int OFS_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] paddr;
        logic              fault;
        cause_e            cause;
        rights_t           rights;
    } rsp_t;

    logic [IDX_W-1:0]  sel_idx;
    logic [IDX_W-1:0]  sel_base;
    logic [ATTR_W-1:0] sel_attr;
    rights_t           sel_rights;
    logic              grant;
    cause_e            cause;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    assign sel_idx = req_vaddr_i[ADDR_W-1:OFS_W];

    region_xlat_table #(
        .IDX_W   (IDX_W),
        .ATTR_W  (ATTR_W),
        .RST_ATTR(ATTR_W'(2))
    ) u_table (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_idx_i (wr_idx_i),
        .wr_base_i(wr_base_i),
        .wr_attr_i(wr_attr_i),
        .rd_idx_i (sel_idx),
        .rd_base_o(sel_base),
        .rd_attr_o(sel_attr)
    );

    region_xlat_perm #(
        .ATTR_W(ATTR_W)
    ) u_perm (
        .attr_i  (sel_attr),
        .rights_o(sel_rights)
    );

    region_xlat_judge u_judge (
        .kind_i  (acc_kind_e'(req_kind_i)),
        .rights_i(sel_rights),
        .grant_o (grant),
        .cause_o (cause)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid_i) begin
            rsp_d.valid  = 1'b1;
            rsp_d.fault  = !grant;
            rsp_d.cause  = cause;
            rsp_d.rights = sel_rights;
            if (grant) begin
                rsp_d.paddr = {sel_base, req_vaddr_i[OFS_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o  = rsp_q.valid;
    assign rsp_paddr_o  = rsp_q.paddr;
    assign rsp_fault_o  = rsp_q.fault;
    assign rsp_cause_o  = rsp_q.cause;
    assign rsp_rights_o = rsp_q.rights;

endmodule

// File: rtl/region_xlat_sva.sv
module region_xlat_sva #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3,
    parameter int ATTR_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic [ADDR_W-1:0] req_vaddr_i,
    input logic [1:0]        req_kind_i,
    input logic              wr_en_i,
    input logic [IDX_W-1:0]  wr_idx_i,
    input logic [IDX_W-1:0]  wr_base_i,
    input logic [ATTR_W-1:0] wr_attr_i,
    input logic              rsp_valid_o,
    input logic [ADDR_W-1:0] rsp_paddr_o,
    input logic              rsp_fault_o,
    input logic [1:0]        rsp_cause_o,
    input logic [2:0]        rsp_rights_o
);
    localparam int OFS_W = ADDR_W - IDX_W;

    a_r8_valid_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> (!rsp_valid_o && !rsp_fault_o && rsp_paddr_o == '0
                          && rsp_cause_o == 2'd0 && rsp_rights_o == 3'd0));

    a_r1_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> (rsp_fault_o
                         || rsp_paddr_o[OFS_W-1:0] == $past(req_vaddr_i[OFS_W-1:0])));

    a_r1_fault_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_fault_o |-> (rsp_paddr_o == '0));

    a_r2_rw_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> (rsp_rights_o[0] == rsp_rights_o[1]));

    a_r4_load_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_kind_i == 2'd0) |=>
            ((rsp_fault_o == !rsp_rights_o[0])
             && (rsp_cause_o == (rsp_fault_o ? 2'd1 : 2'd0))));

    a_r4_fetch_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_kind_i == 2'd2) |=>
            ((rsp_fault_o == !rsp_rights_o[2])
             && (rsp_cause_o == (rsp_fault_o ? 2'd3 : 2'd0))));

    a_r5_bad_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_kind_i == 2'd3) |=> (rsp_fault_o && rsp_cause_o == 2'd2));

endmodule

bind region_xlat region_xlat_sva #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .ATTR_W(ATTR_W)
) u_sva (.*);

// File: tb/test_region_xlat.sv
module test_region_xlat;

    typedef struct {
        logic        valid;
        logic [31:0] paddr;
        logic        fault;
        logic [1:0]  cause;
        logic [2:0]  rights;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [2:0]  wr_base = '0;
    logic [3:0]  wr_attr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [2:0]  rsp_rights;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];
    logic [2:0] m_base [8];
    logic [3:0] m_attr [8];
    string cur_tag = "R8";

    always #10 clk = ~clk;

    region_xlat i_region_xlat (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_valid_i (req_valid),
        .req_vaddr_i (req_vaddr),
        .req_kind_i  (req_kind),
        .wr_en_i     (wr_en),
        .wr_idx_i    (wr_idx),
        .wr_base_i   (wr_base),
        .wr_attr_i   (wr_attr),
        .rsp_valid_o (rsp_valid),
        .rsp_paddr_o (rsp_paddr),
        .rsp_fault_o (rsp_fault),
        .rsp_cause_o (rsp_cause),
        .rsp_rights_o(rsp_rights)
    );

    function automatic exp_t predict(logic v, logic [31:0] va, logic [1:0] k);
        exp_t e;
        logic [2:0] r;
        logic [3:0] a;
        logic rw, ex, ok;
        e.valid = v; e.paddr = '0; e.fault = 0; e.cause = 0; e.rights = 0;
        e.tag = cur_tag;
        if (!v) return e;
        r  = va[31:29];
        a  = m_attr[r];
        rw = a inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd14};
        ex = a inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5};
        case (k)
            2'd0: ok = rw;
            2'd1: ok = rw;
            2'd2: ok = ex;
            default: ok = 1'b0;
        endcase
        e.rights = {ex, rw, rw};
        e.fault  = !ok;
        if (ok) begin
            e.paddr = {m_base[r], va[28:0]};
            e.cause = 2'd0;
        end else begin
            e.cause = (k == 2'd0) ? 2'd1 : (k == 2'd2) ? 2'd3 : 2'd2;
        end
        return e;
    endfunction

    task automatic step(input logic v, input logic [31:0] va, input logic [1:0] k,
                        input logic we, input logic [2:0] wi, input logic [2:0] wb,
                        input logic [3:0] wa);
        @(negedge clk);
        req_valid = v; req_vaddr = va; req_kind = k;
        wr_en = we; wr_idx = wi; wr_base = wb; wr_attr = wa;
        sb.push_back(predict(v, va, k));
        if (we) begin
            m_base[wi] = wb;
            m_attr[wi] = wa;
        end
    endtask

    task automatic req(input logic [31:0] va, input logic [1:0] k);
        step(1'b1, va, k, 1'b0, 3'd0, 3'd0, 4'd0);
    endtask

    task automatic idle();
        step(1'b0, 32'h0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd0);
    endtask

    task automatic wr(input logic [2:0] wi, input logic [2:0] wb, input logic [3:0] wa);
        step(1'b0, 32'h0, 2'd0, 1'b1, wi, wb, wa);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: compares each registered result with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (rsp_valid !== e.valid || rsp_paddr !== e.paddr || rsp_fault !== e.fault
                    || rsp_cause !== e.cause || rsp_rights !== e.rights) begin
                    errors++;
                    $display("FAIL %s: got v=%0b pa=%h f=%0b c=%0d r=%b exp v=%0b pa=%h f=%0b c=%0d r=%b",
                             e.tag, rsp_valid, rsp_paddr, rsp_fault, rsp_cause, rsp_rights,
                             e.valid, e.paddr, e.fault, e.cause, e.rights);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got run still active exp finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_base[i] = 3'(i);
            m_attr[i] = 4'd2;
        end
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (rsp_valid !== 1'b0 || rsp_paddr !== 32'h0 || rsp_fault !== 1'b0
            || rsp_cause !== 2'd0 || rsp_rights !== 3'd0) begin
            errors++;
            $display("FAIL R8 reset outputs: got v=%0b pa=%h f=%0b c=%0d r=%b exp all zero",
                     rsp_valid, rsp_paddr, rsp_fault, rsp_cause, rsp_rights);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R6: identity map and attribute 2 in every region after reset.
        cur_tag = "R6";
        for (int r = 0; r < 8; r++) begin
            req({3'(r), 29'h0ABC_1234 ^ 29'(r * 29'h0111_1111)}, 2'd0);
            req({3'(r), 29'h1FFF_FFFF}, 2'd2);
        end

        cur_tag = "R8";
        idle();
        req(32'h4000_0010, 2'd1);
        idle();
        idle();

        // R2 R3 R4 R5: every attribute code against every kind, region 5.
        for (int a = 0; a < 16; a++) begin
            cur_tag = "R2";
            wr(3'd5, 3'd5, 4'(a));
            cur_tag = "R4";
            req(32'hA000_0040 + 32'(a), 2'd0);
            req(32'hA123_4560, 2'd1);
            cur_tag = "R3";
            req(32'hBFFF_FFF0, 2'd2);
            cur_tag = "R5";
            req(32'hA000_0000, 2'd3);
        end

        // R1: remapped base with a full offset.
        cur_tag = "R1";
        wr(3'd0, 3'd7, 4'd4);
        req(32'h1F0F_0F0F, 2'd0);
        req(32'h0000_0000, 2'd2);

        // R7: write and request to the same region in one cycle.
        cur_tag = "R7";
        step(1'b1, 32'h5000_0100, 2'd0, 1'b1, 3'd2, 3'd6, 4'd15);
        req(32'h5000_0100, 2'd0);
        req(32'h5000_0100, 2'd1);
        step(1'b1, 32'h4000_0200, 2'd2, 1'b1, 3'd2, 3'd3, 4'd1);
        req(32'h4000_0200, 2'd2);
        req(32'h4000_0200, 2'd1);

        cur_tag = "R8";
        idle();
        idle();
        wait (sb.size() == 0);
        @(posedge clk);
        #6;
        summary();
        $finish;
    end

endmodule